// File: doc/BRIEF.md
# ECC Decode Interrupt Status Unit

This unit sits next to a sector-based ECC decoder in a flash controller. The decoder sends one pulse with a sector index each time it finishes a sector. The unit keeps a bitmask of the sectors that have finished in the current operation. It also holds a pending decode flag and an interrupt enable, and drives a level interrupt line to the CPU. Software reaches the unit through a small register port with read and write strobes. Read data comes back one cycle after the read strobe.

Software starts an operation by writing the expected sector count. The unit can report in one of two ways. In per-sector mode every finished sector raises the interrupt. In per-page mode the interrupt is raised once, when every expected sector has finished. Reading the status register clears the pending flag, but only while the enable is set. A sector that finishes after software has read the status sets the flag again. Software sees this as one more interrupt, and can detect the case by reading the done bitmask.

Top module: `ecc_dec_irq_unit`

## Requirements
- R1: After reset the interrupt line is low, read data is zero, the pending flag is clear, the done bitmask is zero and the enable is zero.
- R2: In per-sector mode, with the enable set, every in-range sector pulse sets the pending flag, and the interrupt line is high after that same clock edge.
- R3: A read of STATUS (address 3, bit 0 = pending) returns the pending flag as it was before the read. While the enable is set, the read clears the flag, and the interrupt line is low after the strobe edge.
- R4: While the enable (address 2, bit 0) is zero, a read of STATUS leaves the pending flag set and the interrupt line stays low. Setting the enable afterwards raises the line.
- R5: DONE (address 4) returns a bitmask in which bit i is set once sector i has finished. Bits only accumulate until the next operation start.
- R6: A sector that finishes after a clearing status read sets the pending flag and the interrupt line again.
- R7: In per-page mode (MODE address 1, bit 0 = 1) a partially finished page does not raise the interrupt. The interrupt is raised only on the pulse that completes the expected mask. A repeated pulse after that raises nothing.
- R8: A write to START (address 0) clears the done bitmask and the pending flag, and sets the expected count to wdata[3:0]+1 (1 to 16 sectors). A pulse with a sector index at or above that count has no effect.
- R9: A sector pulse in the same cycle as a clearing status read wins: the pending flag and the interrupt line stay set.
- R10: Read data appears on the output one cycle after the read strobe and holds until the next read. Unmapped addresses read as zero.
- R11: The reporting mode is captured when START is written. A MODE write during an operation does not change how that operation reports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_done_i | input | 1 | Decoder pulse: one sector finished |
| sec_idx_i | input | 4 | Index of the finished sector |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, one cycle after the strobe |
| irq_o | output | 1 | Level decode interrupt |

## Verification
The main function is driven with several patterns, and each one separates a different behaviour:
- Scattered sector indices show that the done bitmask records positions correctly and does not just count pulses.
- A status read followed by a late sector reproduces the re-raised interrupt.
- A read in the same cycle as a sector pulse exposes the wrong priority between clear and set.
- Reads with the enable at zero show whether the clear is gated by the enable.
- Per-page runs with a mode change part-way through tell the captured mode apart from the live register.
- Out-of-range indices and the full 16-sector count probe both ends of the expected mask.

// File: rtl/ecc_irq_pkg.sv
package ecc_irq_pkg;
  localparam int unsigned MAX_SECT = 16;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned ADDR_W   = 3;

  localparam logic [ADDR_W-1:0] A_START = 3'd0;
  localparam logic [ADDR_W-1:0] A_MODE  = 3'd1;
  localparam logic [ADDR_W-1:0] A_IRQEN = 3'd2;
  localparam logic [ADDR_W-1:0] A_STAT  = 3'd3;
  localparam logic [ADDR_W-1:0] A_DONE  = 3'd4;
endpackage

// File: rtl/ecc_sector_tracker.sv
module ecc_sector_tracker #(
  parameter int unsigned MAX_SECT = 16,
  localparam int unsigned IDX_W = $clog2(MAX_SECT)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_i,
  input  logic [IDX_W-1:0]    cnt_field_i,
  input  logic                page_mode_i,
  input  logic                sec_done_i,
  input  logic [IDX_W-1:0]    sec_idx_i,
  output logic [MAX_SECT-1:0] done_q_o,
  output logic [MAX_SECT-1:0] exp_q_o,
  output logic                page_q_o,
  output logic                hit_o,
  output logic                ev_o
);
  logic [MAX_SECT-1:0] done_q, exp_q, exp_d, bit_sel, done_nx;
  logic                page_q;

  // Expected mask for the next operation: sectors 0..cnt_field_i.
  for (genvar i = 0; i < MAX_SECT; i++) begin : g_exp
    assign exp_d[i] = (i <= int'(cnt_field_i));
  end

  always_comb begin
    bit_sel = '0;
    bit_sel[sec_idx_i] = 1'b1;
    hit_o   = sec_done_i && exp_q[sec_idx_i] && !start_i;
    done_nx = done_q | (hit_o ? bit_sel : '0);
    if (page_q)
      ev_o = hit_o && (done_nx == exp_q) && (done_q != exp_q);
    else
      ev_o = hit_o;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q <= '0;
      exp_q  <= '0;
      page_q <= 1'b0;
    end else if (start_i) begin
      done_q <= '0;
      exp_q  <= exp_d;
      page_q <= page_mode_i;
    end else begin
      done_q <= done_nx;
    end
  end

  assign done_q_o = done_q;
  assign exp_q_o  = exp_q;
  assign page_q_o = page_q;
endmodule

// File: rtl/ecc_irq_status.sv
module ecc_irq_status (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic ev_i,
  input  logic rd_clr_i,
  input  logic en_q_i,
  input  logic en_d_i,
  output logic pend_q_o,
  output logic irq_o
);
  logic pend_q, pend_d, irq_q;

  always_comb begin
    if (start_i)                 pend_d = 1'b0;
    else if (ev_i)               pend_d = 1'b1;   // set beats clear
    else if (rd_clr_i && en_q_i) pend_d = 1'b0;
    else                         pend_d = pend_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      irq_q  <= en_d_i && pend_d;
    end
  end

  assign pend_q_o = pend_q;
  assign irq_o    = irq_q;
endmodule

// File: rtl/ecc_irq_regs.sv
module ecc_irq_regs
  import ecc_irq_pkg::*;
#(
  parameter int unsigned MAX_SECT = 16,
  localparam int unsigned IDX_W = $clog2(MAX_SECT)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reg_wr_i,
  input  logic                reg_rd_i,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic [DATA_W-1:0]   reg_wdata_i,
  input  logic                pend_q_i,
  input  logic [MAX_SECT-1:0] done_q_i,
  output logic                start_o,
  output logic [IDX_W-1:0]    cnt_field_o,
  output logic                mode_q_o,
  output logic                en_q_o,
  output logic                en_d_o,
  output logic                rd_stat_o,
  output logic [DATA_W-1:0]   rdata_o
);
  logic              mode_q, mode_d, en_q;
  logic [DATA_W-1:0] rd_mux, rdata_q;

  always_comb begin
    start_o     = reg_wr_i && (reg_addr_i == A_START);
    cnt_field_o = reg_wdata_i[IDX_W-1:0];
    mode_d      = (reg_wr_i && reg_addr_i == A_MODE)  ? reg_wdata_i[0] : mode_q;
    en_d_o      = (reg_wr_i && reg_addr_i == A_IRQEN) ? reg_wdata_i[0] : en_q;
    rd_stat_o   = reg_rd_i && (reg_addr_i == A_STAT);
    rd_mux      = '0;
    case (reg_addr_i)
      A_MODE:  rd_mux[0] = mode_q;
      A_IRQEN: rd_mux[0] = en_q;
      A_STAT:  rd_mux[0] = pend_q_i;
      A_DONE:  rd_mux[MAX_SECT-1:0] = done_q_i;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= 1'b0;
      en_q    <= 1'b0;
      rdata_q <= '0;
    end else begin
      mode_q <= mode_d;
      en_q   <= en_d_o;
      if (reg_rd_i) rdata_q <= rd_mux;
    end
  end

  assign mode_q_o = mode_q;
  assign en_q_o   = en_q;
  assign rdata_o  = rdata_q;
endmodule

// File: rtl/ecc_dec_irq_unit.sv
module ecc_dec_irq_unit
  import ecc_irq_pkg::*;
#(
  localparam int unsigned IDX_W = $clog2(MAX_SECT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sec_done_i,
  input  logic [IDX_W-1:0]  sec_idx_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  logic                start, mode_q, en_q, en_d, rd_stat, pend_q, page_q, hit, ev;
  logic [IDX_W-1:0]    cnt_field;
  logic [MAX_SECT-1:0] done_q, exp_q;

  ecc_irq_regs #(.MAX_SECT(MAX_SECT)) u_regs (
    .clk(clk), .rst(rst), .reg_wr_i(reg_wr_i), .reg_rd_i(reg_rd_i),
    .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i), .pend_q_i(pend_q),
    .done_q_i(done_q), .start_o(start), .cnt_field_o(cnt_field),
    .mode_q_o(mode_q), .en_q_o(en_q), .en_d_o(en_d), .rd_stat_o(rd_stat),
    .rdata_o(reg_rdata_o)
  );

  ecc_sector_tracker #(.MAX_SECT(MAX_SECT)) u_track (
    .clk(clk), .rst(rst), .start_i(start), .cnt_field_i(cnt_field),
    .page_mode_i(mode_q), .sec_done_i(sec_done_i), .sec_idx_i(sec_idx_i),
    .done_q_o(done_q), .exp_q_o(exp_q), .page_q_o(page_q), .hit_o(hit), .ev_o(ev)
  );

  ecc_irq_status u_stat (
    .clk(clk), .rst(rst), .start_i(start), .ev_i(ev), .rd_clr_i(rd_stat),
    .en_q_i(en_q), .en_d_i(en_d), .pend_q_o(pend_q), .irq_o(irq_o)
  );
endmodule

// File: rtl/ecc_dec_irq_chk.sv
module ecc_dec_irq_chk
  import ecc_irq_pkg::*;
(
  input logic                clk,
  input logic                rst,
  input logic                reg_wr_i,
  input logic                reg_rd_i,
  input logic [ADDR_W-1:0]   reg_addr_i,
  input logic                irq_o,
  input logic                en_q,
  input logic                pend_q,
  input logic                page_q,
  input logic                ev,
  input logic                start,
  input logic [MAX_SECT-1:0] done_q,
  input logic [MAX_SECT-1:0] exp_q
);
  logic rd_st, en_wr;
  assign rd_st = reg_rd_i && (reg_addr_i == A_STAT);
  assign en_wr = reg_wr_i && (reg_addr_i == A_IRQEN);

  // R2
  sect_irq_raise_chk: assert property (@(posedge clk) disable iff (rst)
    (ev && en_q && !en_wr) |=> irq_o);

  // R3
  stat_read_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_st && en_q && !ev) |=> !irq_o);

  // R4
  no_clear_disabled_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_st && !en_q && pend_q && !start) |=> pend_q);

  // R9
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_st && ev) |=> pend_q);

  // R5
  done_accum_chk: assert property (@(posedge clk) disable iff (rst)
    !start |=> ((done_q & $past(done_q)) == $past(done_q)));

  // R7
  page_full_only_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(pend_q) && page_q) |-> (done_q == exp_q));
endmodule

bind ecc_dec_irq_unit ecc_dec_irq_chk u_chk (
  .clk(clk), .rst(rst), .reg_wr_i(reg_wr_i), .reg_rd_i(reg_rd_i),
  .reg_addr_i(reg_addr_i), .irq_o(irq_o), .en_q(en_q), .pend_q(pend_q),
  .page_q(page_q), .ev(ev), .start(start), .done_q(done_q), .exp_q(exp_q)
);

// File: tb/ecc_dec_irq_unit_tb.sv
module ecc_dec_irq_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sec_done_i = 1'b0;
  logic [3:0]  sec_idx_i = '0;
  logic        reg_wr_i = 1'b0, reg_rd_i = 1'b0;
  logic [2:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        irq_o;
  int          n_chk = 0, n_err = 0;
  logic [31:0] rv;

  always #2 clk = ~clk;

  ecc_dec_irq_unit u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk); reg_wr_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd_i = 1'b1; reg_addr_i = a;
    @(negedge clk); reg_rd_i = 1'b0; d = reg_rdata_o;
  endtask

  task automatic sec(input logic [3:0] i);
    @(negedge clk); sec_done_i = 1'b1; sec_idx_i = i;
    @(negedge clk); sec_done_i = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 irq", irq_o, 0);
    chk("R1 rdata", reg_rdata_o, 0);
    rd(3'd3, rv); chk("R1 status", rv, 0);
    rd(3'd4, rv); chk("R1 done", rv, 0);
    rd(3'd2, rv); chk("R1 enable", rv, 0);
  endtask

  task automatic t_sector;
    wr(3'd1, 0); wr(3'd2, 1); wr(3'd0, 3);
    sec(4'd0); chk("R2 irq after sector 0", irq_o, 1);
    rd(3'd3, rv); chk("R3 status value", rv, 1);
    chk("R3 irq dropped", irq_o, 0);
    sec(4'd2); chk("R2 irq after sector 2", irq_o, 1);
    rd(3'd4, rv); chk("R5 done mask", rv, 32'h5);
    rd(3'd3, rv); chk("R3 second clear", irq_o, 0);
    sec(4'd2); chk("R2 repeat pulse raises", irq_o, 1);
    rd(3'd4, rv); chk("R5 mask unchanged", rv, 32'h5);
    rd(3'd3, rv);
  endtask

  task automatic t_latency;
    rd(3'd4, rv);
    @(negedge clk); reg_rd_i = 1'b1; reg_addr_i = 3'd2;
    chk("R10 old data before edge", reg_rdata_o, 32'h5);
    @(negedge clk); reg_rd_i = 1'b0;
    chk("R10 new data after edge", reg_rdata_o, 1);
    @(negedge clk); chk("R10 data holds", reg_rdata_o, 1);
    rd(3'd6, rv); chk("R10 unmapped", rv, 0);
  endtask

  task automatic t_race;
    wr(3'd0, 1);
    sec(4'd0);
    rd(3'd3, rv); chk("R6 first read", rv, 1);
    sec(4'd1);
    rd(3'd4, rv); chk("R6 all done", rv, 32'h3);
    chk("R6 line re-raised", irq_o, 1);
    rd(3'd3, rv); chk("R6 status set again", rv, 1);
    chk("R6 cleared", irq_o, 0);
  endtask

  task automatic t_noclr;
    wr(3'd2, 0); wr(3'd0, 0);
    sec(4'd0); chk("R4 line low when disabled", irq_o, 0);
    rd(3'd3, rv); chk("R4 status read", rv, 1);
    rd(3'd3, rv); chk("R4 status not cleared", rv, 1);
    wr(3'd2, 1); chk("R4 enable raises line", irq_o, 1);
    rd(3'd3, rv); chk("R4 clear once enabled", irq_o, 0);
  endtask

  task automatic t_same;
    wr(3'd0, 3);
    sec(4'd0);
    @(negedge clk); reg_rd_i = 1'b1; reg_addr_i = 3'd3; sec_done_i = 1'b1; sec_idx_i = 4'd1;
    @(negedge clk); reg_rd_i = 1'b0; sec_done_i = 1'b0;
    chk("R9 read value", reg_rdata_o, 1);
    chk("R9 line stays", irq_o, 1);
    rd(3'd3, rv); chk("R9 status still set", rv, 1);
  endtask

  task automatic t_page;
    wr(3'd1, 1); wr(3'd0, 2);
    wr(3'd1, 0);
    sec(4'd0); sec(4'd1);
    chk("R7 R11 no irq on partial page", irq_o, 0);
    rd(3'd3, rv); chk("R7 status clear on partial", rv, 0);
    sec(4'd2); chk("R7 irq on full page", irq_o, 1);
    rd(3'd3, rv); chk("R7 status", rv, 1);
    sec(4'd2); chk("R7 no repeat irq", irq_o, 0);
    wr(3'd0, 1);
    sec(4'd0); chk("R11 new start picks sector mode", irq_o, 1);
    rd(3'd3, rv);
  endtask

  task automatic t_start;
    wr(3'd0, 1);
    sec(4'd3); chk("R8 out of range no irq", irq_o, 0);
    rd(3'd4, rv); chk("R8 out of range no mask", rv, 0);
    sec(4'd1); chk("R8 in range irq", irq_o, 1);
    rd(3'd4, rv); chk("R8 mask", rv, 32'h2);
    wr(3'd0, 15); chk("R8 start drops line", irq_o, 0);
    rd(3'd4, rv); chk("R8 start clears mask", rv, 0);
    rd(3'd3, rv); chk("R8 start clears status", rv, 0);
    sec(4'd15); chk("R8 sector 15 of 16", irq_o, 1);
    rd(3'd4, rv); chk("R8 top bit", rv, 32'h8000);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset(); t_sector(); t_latency(); t_race();
        t_noclr(); t_same(); t_page(); t_start();
      end
      begin
        repeat (20000) @(negedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule